// File: doc/BRIEF.md
# Pixel Zero-Suppression Pipeline

This block takes digitized pixel samples (8-bit ADC codes) that arrive one row of column values at a time. It subtracts a stored per-pixel pedestal from each sample and estimates a common-mode offset for the row. It removes that offset and keeps only the pixels whose corrected value reaches a programmable threshold. Each kept pixel becomes a hit word that carries its row address, its column address and its value. A marker word closes every row. Hit words leave through an output FIFO with a valid/ready handshake.

The block buffers each row in two passes. While samples arrive, the pedestal-subtracted values go into a row buffer, and the sum and count of the quiet ones (those below the threshold) are gathered. When the last column has been accepted, the truncated mean becomes the row's common-mode value. The block then replays the buffer, corrects each value, compares it against the threshold and pushes the hits. The sample input stalls during the replay.

Readout is triggered. A trigger pulse arms the next frame, which starts at the sample for row 0, column 0. Frames that were not armed are consumed and produce no output at all. The matrix size is set by parameters; the full sensor (250 columns by 768 rows) is set by overriding them.

Top module: `zs_pipeline`

## Requirements
- R1: After reset, `hit_valid_o` is low and `smp_ready_o` is high.
- R2: The pedestal written through the load port for (row, column) is subtracted from that pixel's sample, and the result is clamped at 0 when the pedestal exceeds the code.
- R3: The common-mode value of a row is the mean of its pedestal-subtracted values that are strictly below `thr_i`, truncated toward zero. It is 0 when no value qualifies. The corrected value is the subtracted value minus the common mode, clamped at 0.
- R4: A pixel produces a hit exactly when its corrected value is at least `thr_i`. Any 8-bit threshold works, including 5.
- R5: A hit word has bit [W-1] = 0, the row in the next RW bits down, the column in the next CW bits, and the corrected value in bits [7:0].
- R6: A trigger pulse arms the next frame to start (row 0, column 0 accepted). This includes a pulse given during the previous frame. A frame that was not armed produces no words.
- R7: After the hits of each row of an armed frame, a marker word is emitted. It has bit [W-1] = 1, the row address, column 0 and value 0, and it is emitted even for a row with no hits.
- R8: The hits of a row come out in increasing column order, and rows come out in input order.
- R9: `smp_ready_o` is low while the FIFO is full or a row is being replayed. A word held at the output stays stable until accepted, and no hit is lost under any amount of output backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample valid |
| smp_ready_o | output | 1 | Sample accepted when high with valid |
| smp_row_i | input | RW | Row address of sample |
| smp_col_i | input | CW | Column address of sample (columns in order) |
| smp_code_i | input | 8 | ADC code |
| ped_we_i | input | 1 | Pedestal write strobe |
| ped_row_i | input | RW | Pedestal row address |
| ped_col_i | input | CW | Pedestal column address |
| ped_val_i | input | 8 | Pedestal value |
| thr_i | input | 8 | Zero-suppression threshold (hold stable while data flows) |
| trig_i | input | 1 | Trigger pulse, arms next frame |
| hit_valid_o | output | 1 | Output word valid |
| hit_ready_i | input | 1 | Output word accepted |
| hit_word_o | output | 1+RW+CW+8 | Hit or row-marker word |

## Verification
If the common-mode accumulator is not cleared between rows, the second row of every frame shows shifted hit values or missing hits. The reference model flags this at the first hit word of that row. A wrong trigger latch shows up as a whole frame of unexpected words, or as missing words, and the end-of-run queue check catches the missing case. Broken backpressure shows up within a few cycles of the FIFO filling, as a lost or duplicated word or as `smp_ready_o` staying high. The held-output test detects this directly.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {ST_ACC, ST_CM, ST_EMIT, ST_MARK} zs_state_e;

  function automatic logic [7:0] sat_sub(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a - b : 8'd0;
  endfunction
endpackage

// File: rtl/zs_ped_mem.sv
module zs_ped_mem #(
  parameter int NCOL = 16,
  parameter int NROW = 4,
  localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int RW = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [RW-1:0] wr_row_i,
  input  logic [CW-1:0] wr_col_i,
  input  logic [7:0]    wr_val_i,
  input  logic [RW-1:0] rd_row_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [7:0]    rd_val_o
);
  localparam int DEPTH = NCOL * NROW;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wa, ra;

  assign wa = AW'(wr_row_i) * AW'(NCOL) + AW'(wr_col_i);
  assign ra = AW'(rd_row_i) * AW'(NCOL) + AW'(rd_col_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa] <= wr_val_i;
  end

  assign rd_val_o = mem[ra];
endmodule

// File: rtl/zs_row_buf.sv
module zs_row_buf #(
  parameter int NCOL = 16,
  localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int NW = $clog2(NCOL + 1),
  localparam int SW = 8 + NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic [7:0]    wr_val_i,
  input  logic [7:0]    thr_i,
  input  logic [CW-1:0] rd_idx_i,
  output logic [7:0]    rd_val_o,
  output logic [7:0]    cm_o
);
  logic [7:0]    buf_q [NCOL];
  logic [SW-1:0] sum_q;
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (we_i) buf_q[wr_idx_i] <= wr_val_i;
  end

  // quiet samples only feed the common-mode estimate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (we_i && (wr_val_i < thr_i)) begin
      sum_q <= sum_q + SW'(wr_val_i);
      cnt_q <= cnt_q + NW'(1);
    end
  end

  assign rd_val_o = buf_q[rd_idx_i];
  assign cm_o     = (cnt_q == '0) ? 8'd0 : 8'(sum_q / SW'(cnt_q));
endmodule

// File: rtl/zs_fifo.sv
module zs_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + NW'(push_i) - NW'(pop_i);
    end
  end

  assign full_o  = (cnt_q == NW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rp_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R9
endmodule

// File: rtl/zs_pipeline.sv
module zs_pipeline #(
  parameter int NCOL = 16,
  parameter int NROW = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int RW = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int HW = 1 + RW + CW + 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  output logic          smp_ready_o,
  input  logic [RW-1:0] smp_row_i,
  input  logic [CW-1:0] smp_col_i,
  input  logic [7:0]    smp_code_i,
  input  logic          ped_we_i,
  input  logic [RW-1:0] ped_row_i,
  input  logic [CW-1:0] ped_col_i,
  input  logic [7:0]    ped_val_i,
  input  logic [7:0]    thr_i,
  input  logic          trig_i,
  output logic          hit_valid_o,
  input  logic          hit_ready_i,
  output logic [HW-1:0] hit_word_o
);
  import zs_pkg::*;

  zs_state_e     state_q;
  logic [CW-1:0] idx_q;
  logic [RW-1:0] row_q;
  logic [7:0]    cm_q, cm_w, ped_rd, sub_val, buf_rd, corr;
  logic          trig_pend_q, frame_sel_q;
  logic          accept, last_col, frame_start, fifo_full, want_hit, push, pop;
  logic [HW-1:0] push_word;

  zs_ped_mem #(.NCOL(NCOL), .NROW(NROW)) u_ped (
    .clk_i, .we_i(ped_we_i), .wr_row_i(ped_row_i), .wr_col_i(ped_col_i),
    .wr_val_i(ped_val_i), .rd_row_i(smp_row_i), .rd_col_i(smp_col_i),
    .rd_val_o(ped_rd)
  );

  assign sub_val     = sat_sub(smp_code_i, ped_rd);
  assign accept      = smp_valid_i && smp_ready_o;
  assign last_col    = (smp_col_i == CW'(NCOL - 1));
  assign frame_start = accept && (smp_row_i == '0) && (smp_col_i == '0);

  zs_row_buf #(.NCOL(NCOL)) u_row (
    .clk_i, .rst_ni, .clr_i(state_q == ST_CM), .we_i(accept),
    .wr_idx_i(smp_col_i), .wr_val_i(sub_val), .thr_i,
    .rd_idx_i(idx_q), .rd_val_o(buf_rd), .cm_o(cm_w)
  );

  assign corr     = sat_sub(buf_rd, cm_q);
  assign want_hit = (state_q == ST_EMIT) && (corr >= thr_i);
  assign push     = (want_hit || state_q == ST_MARK) && !fifo_full;
  assign push_word = (state_q == ST_MARK) ? {1'b1, row_q, CW'(0), 8'd0}
                                          : {1'b0, row_q, idx_q, corr};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_pend_q <= 1'b0;
      frame_sel_q <= 1'b0;
    end else if (frame_start) begin
      frame_sel_q <= trig_pend_q || trig_i;
      trig_pend_q <= 1'b0;
    end else if (trig_i) begin
      trig_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACC;
      idx_q   <= '0;
      row_q   <= '0;
      cm_q    <= '0;
    end else begin
      unique case (state_q)
        ST_ACC: if (accept) begin
          row_q <= smp_row_i;
          if (last_col) state_q <= ST_CM;
        end
        ST_CM: begin
          cm_q  <= cm_w;
          idx_q <= '0;
          state_q <= frame_sel_q ? ST_EMIT : ST_ACC;
        end
        ST_EMIT: if (!(want_hit && fifo_full)) begin
          if (idx_q == CW'(NCOL - 1)) state_q <= ST_MARK;
          else idx_q <= idx_q + CW'(1);
        end
        ST_MARK: if (!fifo_full) state_q <= ST_ACC;
        default: state_q <= ST_ACC;
      endcase
    end
  end

  assign smp_ready_o = (state_q == ST_ACC) && !fifo_full;
  assign pop = hit_valid_o && hit_ready_i;

  zs_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(push_word), .full_o(fifo_full),
    .pop_i(pop), .valid_o(hit_valid_o), .data_o(hit_word_o)
  );

  AST_HIT_ABOVE_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && !hit_word_o[HW-1]) |-> (hit_word_o[7:0] >= thr_i)); // R4
  AST_CM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMIT) |-> (cm_q < thr_i || cm_q == 8'd0)); // R3
  AST_SKIP_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sel_q |-> !push); // R6
  AST_HELD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && !hit_ready_i) |=> (hit_valid_o && $stable(hit_word_o))); // R9
endmodule

// File: tb/tb_zs_pipeline.sv
`timescale 1ns/1ps
module tb_zs_pipeline;
  localparam int NCOL = 16;
  localparam int NROW = 4;
  localparam int CW = $clog2(NCOL);
  localparam int RW = $clog2(NROW);
  localparam int HW = 1 + RW + CW + 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic smp_valid_i = 1'b0, smp_ready_o;
  logic [RW-1:0] smp_row_i = '0, ped_row_i = '0;
  logic [CW-1:0] smp_col_i = '0, ped_col_i = '0;
  logic [7:0] smp_code_i = '0, ped_val_i = '0, thr_i = 8'd5;
  logic ped_we_i = 1'b0, trig_i = 1'b0;
  logic hit_valid_o, hit_ready_i;
  logic [HW-1:0] hit_word_o;

  always #2.5 clk = ~clk;

  zs_pipeline #(.NCOL(NCOL), .NROW(NROW), .FIFO_DEPTH(4)) dut (.clk_i(clk), .*);

  int n_cmp = 0, n_bad = 0, out_cnt = 0, cons_mode = 0;
  bit done = 1'b0;
  logic [HW-1:0] exp_q[$];
  int ped [NROW][NCOL];
  int codes [NROW][NCOL];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] mk(input bit mark, input int r, input int c, input int v);
    return {mark, RW'(r), CW'(c), 8'(v)};
  endfunction

  // behavioural model of one row
  task automatic model_row(input int r);
    int sub[NCOL];
    int sum = 0, cnt = 0, cm, corr;
    for (int c = 0; c < NCOL; c++) begin
      sub[c] = (codes[r][c] > ped[r][c]) ? codes[r][c] - ped[r][c] : 0;
      if (sub[c] < int'(thr_i)) begin sum += sub[c]; cnt++; end
    end
    cm = (cnt == 0) ? 0 : sum / cnt;
    for (int c = 0; c < NCOL; c++) begin
      corr = (sub[c] > cm) ? sub[c] - cm : 0;
      if (corr >= int'(thr_i)) exp_q.push_back(mk(1'b0, r, c, corr));
    end
    exp_q.push_back(mk(1'b1, r, 0, 0));
  endtask

  // consumer and per-clock comparison
  always @(negedge clk) begin
    if (!rst_ni) hit_ready_i = 1'b0;
    else begin
      case (cons_mode)
        0: hit_ready_i = 1'b1;
        1: hit_ready_i = ($urandom_range(0, 2) != 0);
        default: hit_ready_i = 1'b0;
      endcase
      if (hit_valid_o && hit_ready_i) begin
        out_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected word", int'(hit_word_o), 0);
        else begin
          logic [HW-1:0] e;
          e = exp_q.pop_front();
          // R2, R3, R4, R5, R7, R8 word content and order
          check(hit_word_o === e, e[HW-1] ? "R7 marker" : "R2,R3,R4,R5,R8 hit",
                int'(hit_word_o), int'(e));
        end
      end
    end
  end

  task automatic gen(input int kind);
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        int v, k;
        k = $urandom_range(0, 9);
        case (kind)
          0: v = (k == 0) ? ped[r][c] + 80 : (k == 1) ? ped[r][c] - 3
               : ped[r][c] + r + $urandom_range(0, 3);
          1: v = 255;
          default: v = ped[r][c];
        endcase
        codes[r][c] = (v < 0) ? 0 : (v > 255) ? 255 : v;
      end
  endtask

  task automatic send_frame(input bit sel, input bit mid_trig);
    for (int r = 0; r < NROW; r++) begin
      if (sel) model_row(r);
      for (int c = 0; c < NCOL; c++) begin
        @(negedge clk);
        smp_valid_i = 1'b1; smp_row_i = RW'(r); smp_col_i = CW'(c);
        smp_code_i = 8'(codes[r][c]);
        trig_i = mid_trig && (r == NROW - 1) && (c == 0);
        while (!smp_ready_o) @(negedge clk);
      end
    end
    @(negedge clk);
    smp_valid_i = 1'b0; trig_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (NCOL + 8) @(negedge clk);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(smp_ready_o === 1'b1, "R1 ready", int'(smp_ready_o), 1);
    check(hit_valid_o === 1'b0, "R1 valid", int'(hit_valid_o), 0);

    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        @(negedge clk);
        ped[r][c] = $urandom_range(10, 60);
        ped_we_i = 1'b1; ped_row_i = RW'(r); ped_col_i = CW'(c); ped_val_i = 8'(ped[r][c]);
      end
    @(negedge clk); ped_we_i = 1'b0;

    // R2 R3 R4: noisy frame, threshold 5
    thr_i = 8'd5; gen(0); pulse_trig(); send_frame(1'b1, 1'b0); drain();
    // R6: unarmed frame, trigger during its last row arms the next
    c0 = out_cnt; gen(0); send_frame(1'b0, 1'b1); drain();
    check(out_cnt == c0, "R6 unarmed frame output", out_cnt - c0, 0);
    cons_mode = 1; gen(0); send_frame(1'b1, 1'b0); drain();
    // R6: frame after that is unarmed again
    c0 = out_cnt; gen(0); send_frame(1'b0, 1'b0); drain();
    check(out_cnt == c0, "R6 trigger consumed", out_cnt - c0, 0);
    // R3: no quiet samples, common mode 0
    gen(1); pulse_trig(); send_frame(1'b1, 1'b0); drain();
    // R7: rows with no hits still give markers
    c0 = out_cnt; gen(2); pulse_trig(); send_frame(1'b1, 1'b0); drain();
    check(out_cnt - c0 == NROW, "R7 empty rows markers", out_cnt - c0, NROW);
    // R9: output held, input must stall, nothing lost
    cons_mode = 2; thr_i = 8'd0; gen(0); pulse_trig();
    fork
      send_frame(1'b1, 1'b0);
      begin
        repeat (60) @(negedge clk);
        check(smp_ready_o === 1'b0, "R9 ready low when full", int'(smp_ready_o), 0);
        check(hit_valid_o === 1'b1, "R9 word held", int'(hit_valid_o), 1);
        cons_mode = 1;
      end
    join
    drain();
    cons_mode = 0; thr_i = 8'd12; gen(0); pulse_trig(); send_frame(1'b1, 1'b0); drain();
    check(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule